// File: doc/BRIEF.md
# Wired-to-Message Interrupt Pending Bridge

This block turns level-high wired interrupt lines into message-signalled interrupt requests. It holds one pending flag and one enable flag for each source. A source whose pending and enable flags are both set can be dispatched. The block offers one dispatch request at a time, carrying the number of the chosen source. When the transport layer reports that the message has gone out, the block clears that source's pending flag by itself.

Harts use a narrow register-write port to set or clear pending flags and to write enable flags. The pending flag of one source can receive up to three updates in the same cycle: the clear after dispatch, the set from its wire, and a hart write. A fixed ranking decides the result. The post-dispatch clear wins over everything. The wire set wins over any hart write. A hart write takes effect only when neither of the other two touches that bit. Source number 0 is reserved and stays inert.

Top module: `irq_msi_bridge`

## Requirements
- R1: After reset, every pending and enable flag is 0 and `msi_req` is low. With no source raised, enabling sources produces no request.
- R2: A wired line that is high at a rising clock edge sets its source's pending flag at that edge. The line is sampled as a level and synchronously.
- R3: `reg_op` selects the hart operation on source `reg_idx`. 0 does nothing, 1 sets the pending flag, 2 clears the pending flag, and 3 writes `reg_val` into the enable flag.
- R4: Source 0 never becomes pending or enabled. Hart operations on index 0 and a high `wire_in[0]` have no effect.
- R5: When no request is outstanding and some source has both flags set, `msi_req` rises one cycle later and `msi_id` names an eligible source.
- R6: Among eligible sources, the one with the lowest number is dispatched.
- R7: While `msi_req` is high and `msi_ack` is low, `msi_req` stays high and `msi_id` stays unchanged. This holds even if a lower-numbered source becomes eligible meanwhile.
- R8: A completed handshake (`msi_req` and `msi_ack` both high at an edge) clears the dispatched source's pending flag at that edge. This clear overrides a high wire and a hart set on the same source in the same cycle.
- R9: A wire set in the same cycle as a hart clear of the same source leaves the pending flag set.
- R10: Updates to different sources in the same cycle all take effect. A handshake clear on one source does not block a wire set or hart set on another.
- R11: After a completed handshake, `msi_req` is low for the next cycle before any new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wire_in | input | NUM_SRC | Level-high wired interrupt lines, one per source |
| reg_op | input | 2 | Hart operation code (see R3) |
| reg_idx | input | ID_W | Source number addressed by the hart operation |
| reg_val | input | 1 | Value written to the enable flag for operation 3 |
| msi_req | output | 1 | A message request is outstanding |
| msi_id | output | ID_W | Source number carried by the outstanding request |
| msi_ack | input | 1 | The message for the outstanding request has been sent |

## Verification
The handshake clear, the wire set and the hart write can all hit the same pending flag in one cycle. The bench provokes this in three ways. It completes a handshake while that source's wire is still high and a hart set targets it. It raises a wire while a hart clears the same flag. It completes a handshake on one source while another source receives a wire set and a third receives a hart set. The bench judges the outcome only at the ports. A source that is left pending and enabled must show up later as a dispatch with the expected number and in the expected order. A flag that is cleared must produce no dispatch at all during a quiet window.

// File: rtl/irq_msi_pkg.sv
// Shared types for the wired-to-message interrupt bridge.
// Assumes: hart operation codes are two bits wide and fixed by the port contract.
package irq_msi_pkg;

    typedef enum logic [1:0] {
        HOP_NONE   = 2'd0,
        HOP_SET_IP = 2'd1,
        HOP_CLR_IP = 2'd2,
        HOP_WR_IE  = 2'd3
    } hop_e;

endpackage

// File: rtl/ip_ie_bank.sv
// Per-source pending and enable storage with ranked update resolution.
// For each pending bit: post-dispatch clear > wire set > hart set/clear > hold.
// Assumes: source 0 is reserved, so its flags are tied to 0.
module ip_ie_bank
    import irq_msi_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] wire_in,
    input  hop_e               hop,
    input  logic [ID_W-1:0]    hop_idx,
    input  logic               hop_val,
    input  logic               clr_fire,
    input  logic [ID_W-1:0]    clr_idx,
    output logic [NUM_SRC-1:0] ip_q,
    output logic [NUM_SRC-1:0] ie_q
);

    logic [NUM_SRC-1:0] ip_nxt;
    logic [NUM_SRC-1:0] ie_nxt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (g == 0) begin : g_reserved
            assign ip_nxt[g] = 1'b0;
            assign ie_nxt[g] = 1'b0;
        end else begin : g_live
            logic hit_hart;
            logic hit_clr;
            assign hit_hart = (hop_idx == ID_W'(g));
            assign hit_clr  = clr_fire && (clr_idx == ID_W'(g));

            // Resolve the ranked updates of one pending bit.
            always_comb begin
                if (hit_clr)
                    ip_nxt[g] = 1'b0;
                else if (wire_in[g])
                    ip_nxt[g] = 1'b1;
                else if (hit_hart && hop == HOP_SET_IP)
                    ip_nxt[g] = 1'b1;
                else if (hit_hart && hop == HOP_CLR_IP)
                    ip_nxt[g] = 1'b0;
                else
                    ip_nxt[g] = ip_q[g];
            end

            // Enable bit follows hart writes only.
            assign ie_nxt[g] = (hit_hart && hop == HOP_WR_IE) ? hop_val : ie_q[g];
        end
    end

    // Register all flags; reset clears every one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= '0;
            ie_q <= '0;
        end else begin
            ip_q <= ip_nxt;
            ie_q <= ie_nxt;
        end
    end

endmodule

// File: rtl/lowest_pick.sv
// Finds the lowest-numbered set bit of a candidate vector.
// Assumes: purely combinational; idx is 0 when found is low.
module lowest_pick #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               found,
    output logic [ID_W-1:0]    idx
);

    // Scan from the top so the last match taken is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/msi_issue.sv
// Holds the single outstanding message request and its source number.
// Assumes: a handshake completes on a cycle where req and ack are both high;
// the request then drops for one cycle before a new pick is taken.
module msi_issue #(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            found,
    input  logic [ID_W-1:0] pick_idx,
    input  logic            ack,
    output logic            req,
    output logic [ID_W-1:0] id
);

    // Launch on a fresh pick, hold until acknowledged, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
            id  <= '0;
        end else if (req) begin
            if (ack)
                req <= 1'b0;
        end else if (found) begin
            req <= 1'b1;
            id  <= pick_idx;
        end
    end

endmodule

// File: rtl/irq_msi_bridge.sv
// Top: wired interrupt lines in, one message request at a time out.
// Assumes: wires are level-high and synchronous to clk; one hart operation per cycle.
module irq_msi_bridge
    import irq_msi_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] wire_in,
    input  logic [1:0]         reg_op,
    input  logic [ID_W-1:0]    reg_idx,
    input  logic               reg_val,
    output logic               msi_req,
    output logic [ID_W-1:0]    msi_id,
    input  logic               msi_ack
);

    logic [NUM_SRC-1:0] ip_q;
    logic [NUM_SRC-1:0] ie_q;
    logic               found;
    logic [ID_W-1:0]    pick_idx;
    logic               clr_fire;
    hop_e               hop;

    assign hop      = hop_e'(reg_op);
    assign clr_fire = msi_req && msi_ack;

    ip_ie_bank #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wire_in  (wire_in),
        .hop      (hop),
        .hop_idx  (reg_idx),
        .hop_val  (reg_val),
        .clr_fire (clr_fire),
        .clr_idx  (msi_id),
        .ip_q     (ip_q),
        .ie_q     (ie_q)
    );

    lowest_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .cand  (ip_q & ie_q),
        .found (found),
        .idx   (pick_idx)
    );

    msi_issue #(.ID_W(ID_W)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .found    (found),
        .pick_idx (pick_idx),
        .ack      (msi_ack),
        .req      (msi_req),
        .id       (msi_id)
    );

endmodule

// File: rtl/irq_msi_bridge_chk.sv
// Property checker for irq_msi_bridge, attached by bind below.
// Assumes: observes ports plus the pending/enable vectors of the top.
module irq_msi_bridge_chk #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] wire_in,
    input logic               msi_req,
    input logic               msi_ack,
    input logic [ID_W-1:0]    msi_id,
    input logic [NUM_SRC-1:0] ip_q,
    input logic [NUM_SRC-1:0] ie_q
);

    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] want_set;
    logic [NUM_SRC-1:0] elig;

    assign ack_mask = (msi_req && msi_ack) ? (NUM_SRC'(1) << msi_id) : '0;
    assign want_set = wire_in & ~ack_mask & ~NUM_SRC'(1);
    assign elig     = ip_q & ie_q;

    AST_WIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((ip_q & $past(want_set)) == $past(want_set))); // R2
    AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ip_q[0] && !ie_q[0]); // R4
    AST_PICK_ELIG: assert property (@(posedge clk) disable iff (!rst_n) $rose(msi_req) |-> ((($past(elig) >> msi_id) & NUM_SRC'(1)) != '0)); // R5
    AST_PICK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(msi_req) |-> (($past(elig) & ((NUM_SRC'(1) << msi_id) - NUM_SRC'(1))) == '0)); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) msi_req && !msi_ack |=> msi_req && $stable(msi_id)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) msi_req && msi_ack |=> !ip_q[$past(msi_id)]); // R8
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) msi_req && msi_ack |=> !msi_req); // R11

endmodule

bind irq_msi_bridge irq_msi_bridge_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wire_in (wire_in),
    .msi_req (msi_req),
    .msi_ack (msi_ack),
    .msi_id  (msi_id),
    .ip_q    (ip_q),
    .ie_q    (ie_q)
);

// File: tb/test_irq_msi_bridge.sv
module test_irq_msi_bridge;
    localparam int N = 32;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] wire_in = '0;
    logic [1:0]   reg_op = 2'd0;
    logic [W-1:0] reg_idx = '0;
    logic         reg_val = 1'b0;
    logic         msi_req;
    logic [W-1:0] msi_id;
    logic         msi_ack = 1'b0;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    ended = 0;

    always #4 clk = ~clk;

    irq_msi_bridge #(.NUM_SRC(N), .ID_W(W)) i_irq_msi_bridge (
        .clk(clk), .rst_n(rst_n), .wire_in(wire_in), .reg_op(reg_op),
        .reg_idx(reg_idx), .reg_val(reg_val), .msi_req(msi_req),
        .msi_id(msi_id), .msi_ack(msi_ack)
    );

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic hop(int op, int idx, bit val);
        reg_op = 2'(op); reg_idx = W'(idx); reg_val = val;
        step();
        reg_op = 2'd0;
    endtask

    task automatic quiet(int n, string rq);
        for (int k = 0; k < n; k++) begin
            step();
            check(!msi_req, rq, int'(msi_req), 0);
        end
    endtask

    task automatic ack_expect(int id, string rq);
        int waited = 0;
        while (!msi_req && waited < 40) begin
            step();
            waited++;
        end
        if (!msi_req) begin
            check(1'b0, rq, 0, id);
        end else begin
            exp_q.push_back(id); tag_q.push_back(rq);
            msi_ack = 1'b1;
            step();
            msi_ack = 1'b0;
            check(!msi_req, "R11", int'(msi_req), 0);
        end
    endtask

    // Monitor: every handshake seen is popped against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && msi_req && msi_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", int'(msi_id), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(msi_id) == e, t, int'(msi_id), e);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        check(!msi_req, "R1", int'(msi_req), 0);
        // R1: enable all sources with no wire raised: nothing pending
        for (int s = 1; s < N; s++) hop(3, s, 1'b1);
        quiet(3, "R1");
        for (int s = 1; s < N; s++) hop(3, s, 1'b0);

        // R4: source 0 inert
        hop(3, 0, 1'b1);
        hop(1, 0, 1'b0);
        wire_in[0] = 1'b1;
        quiet(4, "R4");
        wire_in[0] = 1'b0;

        // R2 / R5: wire pulse on enabled source 5
        hop(3, 5, 1'b1);
        wire_in[5] = 1'b1; step(); wire_in[5] = 1'b0; step();
        check(msi_req && msi_id == W'(5), "R5", int'(msi_id), 5);
        ack_expect(5, "R2");
        quiet(3, "R8");

        // R6 / R7: three at once, then a lower one while outstanding
        hop(3, 1, 1'b1); hop(3, 3, 1'b1); hop(3, 7, 1'b1); hop(3, 9, 1'b1);
        wire_in[3] = 1'b1; wire_in[7] = 1'b1; wire_in[9] = 1'b1; step();
        wire_in = '0; step();
        check(msi_req && msi_id == W'(3), "R6", int'(msi_id), 3);
        wire_in[1] = 1'b1; step(); wire_in[1] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check(msi_req && msi_id == W'(3), "R7", int'(msi_id), 3);
        end
        ack_expect(3, "R6");
        ack_expect(1, "R6");
        ack_expect(7, "R6");
        ack_expect(9, "R6");
        quiet(2, "R6");

        // R8: handshake clear beats a high wire and a hart set
        hop(3, 12, 1'b1);
        wire_in[12] = 1'b1; step(); step();
        check(msi_req && msi_id == W'(12), "R8", int'(msi_id), 12);
        exp_q.push_back(12); tag_q.push_back("R8");
        msi_ack = 1'b1; reg_op = 2'd1; reg_idx = W'(12);
        step();
        msi_ack = 1'b0; reg_op = 2'd0; wire_in[12] = 1'b0;
        quiet(4, "R8");

        // R9: wire set beats hart clear in the same cycle
        wire_in[20] = 1'b1; reg_op = 2'd2; reg_idx = W'(20);
        step();
        wire_in[20] = 1'b0; reg_op = 2'd0;
        hop(3, 20, 1'b1);
        ack_expect(20, "R9");

        // R3: hart set, clear and enable writes
        hop(1, 25, 1'b0); hop(2, 25, 1'b0); hop(3, 25, 1'b1);
        quiet(3, "R3");
        hop(1, 25, 1'b0);
        ack_expect(25, "R3");
        hop(3, 25, 1'b0); hop(1, 25, 1'b0);
        quiet(3, "R3");
        hop(3, 25, 1'b1);
        ack_expect(25, "R3");

        // R10: clear of one source alongside sets of two others
        hop(3, 2, 1'b1); hop(3, 4, 1'b1); hop(3, 6, 1'b1);
        wire_in[2] = 1'b1; step(); wire_in[2] = 1'b0; step();
        check(msi_req && msi_id == W'(2), "R10", int'(msi_id), 2);
        exp_q.push_back(2); tag_q.push_back("R10");
        msi_ack = 1'b1; wire_in[4] = 1'b1; reg_op = 2'd1; reg_idx = W'(6);
        step();
        msi_ack = 1'b0; wire_in[4] = 1'b0; reg_op = 2'd0;
        ack_expect(4, "R10");
        ack_expect(6, "R10");
        quiet(3, "R10");

        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        finish_run();
    end
endmodule